// File: doc/BRIEF.md
# 3x3 Gaussian Smoothing Engine

This block smooths an 8-bit grayscale image that already sits in a synchronous on-chip memory. It takes a start pulse, then walks every output pixel in raster order. For each pixel it reads nine coefficients from a small coefficient memory and the matching 3x3 neighbourhood from the image memory. It multiplies and accumulates the pairs, divides the sum by 256 with a right shift, and writes one byte to a result memory.

The coefficient memory normally holds the integer kernel 3, 21, 3 / 21, 158, 21 / 3, 21, 3. This is a scaled approximation of a Gaussian with standard deviation 0.5, and its weights sum to 254. The engine does not assume a symmetric kernel: any nine weights can be loaded. Neighbour positions that fall outside the image count as zero, so the result is the same size as the input. All three memories are outside the block, and each read returns its data one clock after the enable.

Top module: `gauss3x3_engine`

## Requirements
- R1: Tap k (k = 0..8) reads coefficient address k and pairs it with the pixel at row offset k/3-1 and column offset k%3-1 from the output position. The kernel is stored row-major, and the pairing holds for asymmetric kernels.
- R2: The written value is the sum of the nine products shifted right by 8 (floor division by 256).
- R3: If the shifted sum exceeds 255, the written value is 255.
- R4: Neighbours outside the image contribute zero, and no image read is issued for them. A W x H frame therefore issues exactly (3W-2)(3H-2) image reads, and every image address is below W*H.
- R5: Each frame writes every pixel once, in raster order, at result address row*IMG_W+col.
- R6: Every pixel takes 11 cycles: nine read cycles (data returns one cycle after the enable), one drain cycle and one write cycle. `done` is seen 11*W*H+1 cycles after the edge that samples `start`.
- R7: `done` is high for exactly one cycle, in the cycle after the final write. The engine then returns to idle, and a later `start` runs a new frame.
- R8: A `start` received while a frame is in progress is ignored: no extra writes and no restart.
- R9: After reset, `done` and all memory enables stay low until `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (sampled while idle) |
| done | output | 1 | One-cycle frame-complete pulse |
| coef_re | output | 1 | Coefficient memory read enable |
| coef_addr | output | 4 | Coefficient address 0..8 |
| coef_rdata | input | COEF_W | Coefficient read data, one cycle after the enable |
| img_re | output | 1 | Image memory read enable |
| img_addr | output | ADDR_W | Image pixel address |
| img_rdata | input | PIX_W | Image read data, one cycle after the enable |
| res_we | output | 1 | Result memory write enable |
| res_addr | output | ADDR_W | Result address |
| res_wdata | output | PIX_W | Filtered pixel |

## Verification
The bench loads an asymmetric kernel so that a wrong tap-to-offset pairing, or a coefficient read one tap off, would give wrong values instead of being masked by symmetry. Constant-255 images are used in two ways: with the normal kernel they expose border handling, where a design that reads wrapped addresses instead of zero would inflate edge pixels; with all-255 weights they drive the sum far past 255, where a missing clamp would write the wrapped low byte. The bench counts image reads and cycles per frame, so a design that fetches out-of-range neighbours or mistimes its read latency breaks the exact totals. A start pulse in mid-frame catches a design that restarts or writes extra pixels.

// File: rtl/gauss3x3_engine.sv
module gauss3x3_engine #(
  parameter int IMG_W  = 8,
  parameter int IMG_H  = 6,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int SHIFT  = 8,
  localparam int NPIX   = IMG_W * IMG_H,
  localparam int ADDR_W = $clog2(NPIX),
  localparam int COL_W  = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int ROW_W  = (IMG_H > 1) ? $clog2(IMG_H) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              coef_re,
  output logic [3:0]        coef_addr,
  input  logic [COEF_W-1:0] coef_rdata,
  output logic              img_re,
  output logic [ADDR_W-1:0] img_addr,
  input  logic [PIX_W-1:0]  img_rdata,
  output logic              res_we,
  output logic [ADDR_W-1:0] res_addr,
  output logic [PIX_W-1:0]  res_wdata
);
  localparam int ACC_W  = PIX_W + COEF_W + 4;
  localparam int PROD_W = PIX_W + COEF_W;
  localparam int AW2    = ADDR_W + 2;
  localparam int HI_W   = ACC_W - SHIFT;

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_DRAIN, S_WRITE, S_FIN} state_t;
  state_t state;

  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic [ADDR_W-1:0] pix_addr;
  logic [1:0]        tr, tc;
  logic [3:0]        k;
  logic [ACC_W-1:0]  acc;
  logic              tap_v, tap_z;

  logic              row_ok, col_ok, nb_ok, last_pix;
  logic [AW2-1:0]    nb_addr;
  logic [PIX_W-1:0]  pix_eff;
  logic [PROD_W-1:0] prod;
  logic [HI_W-1:0]   shf;

  assign row_ok   = !(tr == 2'd0 && row == '0) &&
                    !(tr == 2'd2 && row == ROW_W'(IMG_H-1));
  assign col_ok   = !(tc == 2'd0 && col == '0) &&
                    !(tc == 2'd2 && col == COL_W'(IMG_W-1));
  assign nb_ok    = row_ok && col_ok;
  assign nb_addr  = AW2'(pix_addr)
                  + ((tr == 2'd0) ? AW2'(0) : (tr == 2'd1) ? AW2'(IMG_W) : AW2'(2*IMG_W))
                  + AW2'(tc) - AW2'(IMG_W + 1);
  assign last_pix = (pix_addr == ADDR_W'(NPIX-1));

  assign pix_eff  = tap_z ? '0 : img_rdata;
  assign prod     = coef_rdata * pix_eff;
  assign shf      = acc[ACC_W-1:SHIFT];

  assign coef_re   = (state == S_RUN);
  assign coef_addr = k;
  assign img_re    = (state == S_RUN) && nb_ok;
  assign img_addr  = nb_addr[ADDR_W-1:0];
  assign res_we    = (state == S_WRITE);
  assign res_addr  = pix_addr;
  assign res_wdata = (|shf[HI_W-1:PIX_W]) ? {PIX_W{1'b1}} : shf[PIX_W-1:0];
  assign done      = (state == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      row      <= '0;
      col      <= '0;
      pix_addr <= '0;
      tr       <= '0;
      tc       <= '0;
      k        <= '0;
      acc      <= '0;
      tap_v    <= 1'b0;
      tap_z    <= 1'b0;
    end else begin
      tap_v <= (state == S_RUN);
      tap_z <= !nb_ok;
      if (tap_v) acc <= acc + ACC_W'(prod);
      case (state)
        S_IDLE: if (start) begin
          state    <= S_RUN;
          row      <= '0;
          col      <= '0;
          pix_addr <= '0;
          tr       <= '0;
          tc       <= '0;
          k        <= '0;
          acc      <= '0;
        end
        S_RUN: begin
          k <= k + 4'd1;
          if (tc == 2'd2) begin
            tc <= '0;
            tr <= tr + 2'd1;
          end else begin
            tc <= tc + 2'd1;
          end
          if (k == 4'd8) state <= S_DRAIN;
        end
        S_DRAIN: state <= S_WRITE;
        S_WRITE: begin
          acc <= '0;
          tr  <= '0;
          tc  <= '0;
          k   <= '0;
          if (last_pix) begin
            state <= S_FIN;
          end else begin
            state    <= S_RUN;
            pix_addr <= pix_addr + ADDR_W'(1);
            if (col == COL_W'(IMG_W-1)) begin
              col <= '0;
              row <= row + ROW_W'(1);
            end else begin
              col <= col + COL_W'(1);
            end
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gauss3x3_chk.sv
module gauss3x3_chk #(
  parameter int IMG_W  = 8,
  parameter int IMG_H  = 6,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              coef_re,
  input logic [3:0]        coef_addr,
  input logic              img_re,
  input logic [ADDR_W-1:0] img_addr,
  input logic              res_we,
  input logic [ADDR_W-1:0] res_addr
);
  localparam int NPIX = IMG_W * IMG_H;
  logic [ADDR_W:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wcnt <= '0;
    else if (done)   wcnt <= '0;
    else if (res_we) wcnt <= wcnt + 1'b1;
  end

  p_coef_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    coef_re |-> coef_addr < 4'd9);
  p_img_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    img_re |-> int'(img_addr) < NPIX);
  p_write_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> {1'b0, res_addr} == wcnt);
  p_write_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |=> !res_we);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> int'(wcnt) == NPIX);
  p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !coef_re && !img_re && !res_we);
endmodule

bind gauss3x3_engine gauss3x3_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done),
  .coef_re(coef_re), .coef_addr(coef_addr),
  .img_re(img_re), .img_addr(img_addr),
  .res_we(res_we), .res_addr(res_addr)
);

// File: tb/sim_gauss3x3_engine.sv
`timescale 1ns/1ps
module sim_gauss3x3_engine;
  localparam int W = 8, H = 6, NPIX = W * H, AW = $clog2(NPIX);
  localparam int READS = (3*W - 2) * (3*H - 2);

  logic clk = 0, rst_n = 0, start = 0;
  logic done, coef_re, img_re, res_we;
  logic [3:0] coef_addr;
  logic [7:0] coef_rdata = 0, img_rdata = 0, res_wdata;
  logic [AW-1:0] img_addr, res_addr;

  int coef_mem [9];
  int img_mem  [NPIX];
  int exp_addr [$];
  int exp_data [$];
  int checks = 0, fails = 0, rd_cnt = 0, cyc = 0;

  always #4 clk = ~clk;

  gauss3x3_engine #(.IMG_W(W), .IMG_H(H)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .coef_re(coef_re), .coef_addr(coef_addr), .coef_rdata(coef_rdata),
    .img_re(img_re), .img_addr(img_addr), .img_rdata(img_rdata),
    .res_we(res_we), .res_addr(res_addr), .res_wdata(res_wdata));

  always @(posedge clk) begin
    if (coef_re) coef_rdata <= 8'(coef_mem[coef_addr]);
    if (img_re)  img_rdata  <= 8'(img_mem[img_addr]);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (img_re) rd_cnt++;
      if (res_we) begin
        if (exp_addr.size() == 0) check(0, "R8 unexpected write", int'(res_addr), -1);
        else begin
          int ea, ed;
          ea = exp_addr.pop_front();
          ed = exp_data.pop_front();
          check(int'(res_addr) == ea, "R5 write address", int'(res_addr), ea);
          check(int'(res_wdata) == ed, "R1/R2/R3 pixel value", int'(res_wdata), ed);
        end
      end
      if (done) begin
        check(exp_addr.size() == 0, "R7 writes pending at done", exp_addr.size(), 0);
        check(rd_cnt == READS, "R4 image read count", rd_cnt, READS);
        rd_cnt = 0;
      end
    end
  end

  function automatic int model(int r, int c);
    int s = 0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) begin
        int rr = r + i - 1, cc = c + j - 1;
        if (rr >= 0 && rr < H && cc >= 0 && cc < W)
          s += coef_mem[i*3 + j] * img_mem[rr*W + cc];
      end
    s = s >> 8;
    return (s > 255) ? 255 : s;
  endfunction

  task automatic run_frame(input bit poke);
    int n = 0;
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        exp_addr.push_back(r*W + c);
        exp_data.push_back(model(r, c));
      end
    @(negedge clk); start = 1;
    @(negedge clk); start = 0; n = 1;
    while (!done && n < 5000) begin
      if (poke && n == 100) start = 1;
      else start = 0;
      @(negedge clk); n++;
    end
    start = 0;
    check(n == 11*NPIX + 1, "R6 cycles to done", n, 11*NPIX + 1);
    @(negedge clk);
    check(!done, "R7 done one cycle", done, 0);
    repeat (20) @(negedge clk);
  endtask

  task automatic set_gauss();
    coef_mem = '{3, 21, 3, 21, 158, 21, 3, 21, 3};
  endtask

  initial begin
    set_gauss();
    for (int i = 0; i < NPIX; i++) img_mem[i] = 0;
    repeat (3) @(negedge clk);
    check(!done && !coef_re && !img_re && !res_we, "R9 reset state",
          {done, coef_re, img_re, res_we}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(!done && !coef_re && !img_re && !res_we, "R9 idle before start",
          {done, coef_re, img_re, res_we}, 0);

    // R2 gradient image, normal kernel
    for (int i = 0; i < NPIX; i++) img_mem[i] = (i * 5) % 256;
    run_frame(0);
    // R8 scattered image with start poked mid-frame
    for (int i = 0; i < NPIX; i++) img_mem[i] = ((i / W) * 37 + (i % W) * 91 + 13) % 256;
    run_frame(1);
    // R1 asymmetric kernel
    coef_mem = '{1, 2, 4, 8, 16, 32, 64, 100, 27};
    run_frame(0);
    // R4 constant image: borders lose zeroed neighbours
    set_gauss();
    for (int i = 0; i < NPIX; i++) img_mem[i] = 255;
    run_frame(0);
    // R3 saturation
    for (int i = 0; i < 9; i++) coef_mem[i] = 255;
    run_frame(0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule